// File: doc/BRIEF.md
# I2S stereo DAC transmitter (clock master)

This block is the clock-master side of a serial link to a stereo audio DAC using the Philips I2S framing. It runs on the master clock, passes that clock to the DAC, and derives two clocks from it. The bit clock is one quarter of the master clock. The word-select clock marks the left and right halves of every frame. Each channel word is 24 bits wide, so a stereo frame lasts 48 bit-clock periods, or 192 master-clock cycles with the default parameters.

Once per frame the block asks for a new stereo pair. A one-cycle request strobe comes first. The acceptance slot follows in the next cycle, and there a ready/valid handshake takes the pair straight into a single 48-bit shift register. The block has no FIFO. If the source misses the slot, the previous pair is sent again and an underrun flag shows this for that frame. Each word goes out MSB first, one bit slot late relative to its word-select edge. The bit slot just after each word-select edge therefore carries the LSB of the word that came before.

Top module: `i2s_dac_tx`

## Requirements
- R1: `mclk_o` follows `clk`. `sck_o` has a period of 4 `clk` cycles and is high for 2 of them.
- R2: `lrck_o` toggles every 24 `sck_o` periods, low for the left word and high for the right word. It changes only in the `clk` cycle where `sck_o` falls.
- R3: `sdata_o` changes only in the `clk` cycle where `sck_o` falls, so it is stable at every rising edge of `sck_o`.
- R4: Each 24-bit word is sent MSB first. Its MSB sits in the second bit slot after the `lrck_o` edge that starts its half-frame. Its LSB sits in the first bit slot after the next `lrck_o` edge.
- R5: `frame_req_o` is high for one `clk` cycle once per frame, every 192 `clk` cycles. `pair_ready_o` is high in the following cycle.
- R6: `pair_ready_o` is high for exactly one `clk` cycle per frame. A pair is taken when `pair_valid_i` and `pair_ready_o` are both high. `pair_left_i` goes out in the left half-frame and `pair_right_i` in the right half-frame, bit-exact as two's-complement codes, including the full-scale codes 0x800000 and 0x7FFFFF.
- R7: If `pair_valid_i` is low while `pair_ready_o` is high, the previously accepted pair is sent again and `underrun_o` is 1 until the next acceptance slot. An accepted pair sets `underrun_o` to 0.
- R8: While `rst_n` is low at a rising `clk` edge, `sck_o`, `lrck_o`, `sdata_o`, `frame_req_o`, `pair_ready_o` and `underrun_o` go low (synchronous, active-low reset). The stored pair is cleared, so an underrun in the first frame after reset sends all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master audio clock; all logic runs on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| pair_left_i | input | 24 | Left-channel sample, two's complement |
| pair_right_i | input | 24 | Right-channel sample, two's complement |
| pair_valid_i | input | 1 | Source presents a stereo pair |
| pair_ready_o | output | 1 | Acceptance slot; the pair is taken when valid is also high |
| frame_req_o | output | 1 | One-cycle strobe one cycle before the acceptance slot |
| underrun_o | output | 1 | The current frame repeats the previous pair because no pair was offered |
| mclk_o | output | 1 | Master clock forwarded to the DAC |
| sck_o | output | 1 | Bit clock, master clock divided by 4 |
| lrck_o | output | 1 | Word select: low for left, high for right |
| sdata_o | output | 1 | Serial data, MSB first with a one-slot delay |

## Verification
The bench decodes the serial stream the way a DAC would, sampling at each rising bit-clock edge. The main corner case is the one-slot delay. A design that puts the MSB right on the word-select edge decodes as words shifted by one bit, with the LSB carried into the wrong channel. Full-scale codes and single-bit patterns at the MSB and LSB positions expose a dropped or swapped bit, and expose a design that swaps the channels under the word-select polarity. Missed acceptance slots, including the first frame after reset, must repeat the last pair (zeros after reset) and raise the underrun flag. A design that sends stale shift-register contents or leaves the flag set gives wrong words or a wrong flag. Edge monitors catch any word-select or data change away from a bit-clock falling edge, and a mid-frame reset must drive the serial outputs low at once.

// File: rtl/i2s_tx_pkg.sv
// Package: i2s_tx_pkg
// Shared defaults and types for the I2S DAC transmitter.
// Assumes: one master clock domain; the bit-clock divide is even and at least 4.
package i2s_tx_pkg;

    // Default width of one channel word in bits.
    localparam int unsigned WORD_W_DEF   = 24;
    // Default number of master-clock cycles per bit-clock period.
    localparam int unsigned MCLK_DIV_DEF = 4;

    // Word-select level for each channel.
    typedef enum logic {
        CH_LEFT  = 1'b0,
        CH_RIGHT = 1'b1
    } chan_e;

    // Bits in one stereo frame.
    function automatic int unsigned frame_bits(input int unsigned word_w);
        return 2 * word_w;
    endfunction

    // Channel that owns a bit slot (the first half of the frame is left).
    function automatic chan_e slot_chan(input int unsigned slot, input int unsigned word_w);
        return (slot >= word_w) ? CH_RIGHT : CH_LEFT;
    endfunction

endpackage

// File: rtl/i2s_tx_clkgen.sv
// Module: i2s_tx_clkgen
// Divides the master clock into the bit clock. It also gives two timing
// strobes: fall_o is high in the cycle whose closing edge drives sck_o low,
// and prefall_o is high one cycle before that.
// Assumes: DIV is even and >= 4; synchronous active-low reset.
module i2s_tx_clkgen #(
    parameter int unsigned DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic sck_o,
    output logic fall_o,
    output logic prefall_o
);
    localparam int unsigned PH_W    = $clog2(DIV);
    localparam int unsigned PH_LAST = DIV - 1;
    localparam int unsigned PH_RISE = DIV / 2 - 1;
    localparam int unsigned PH_PRE  = DIV - 2;

    logic [PH_W-1:0] ph_q;
    logic            sck_q;

    // Phase counter within one bit-clock period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q <= '0;
        end else if (ph_q == PH_W'(PH_LAST)) begin
            ph_q <= '0;
        end else begin
            ph_q <= ph_q + 1'b1;
        end
    end

    // Bit clock register: goes high mid-period and low at the period end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_q <= 1'b0;
        end else if (ph_q == PH_W'(PH_RISE)) begin
            sck_q <= 1'b1;
        end else if (ph_q == PH_W'(PH_LAST)) begin
            sck_q <= 1'b0;
        end
    end

    assign sck_o     = sck_q;
    assign fall_o    = (ph_q == PH_W'(PH_LAST));
    assign prefall_o = (ph_q == PH_W'(PH_PRE));

endmodule

// File: rtl/i2s_tx_slotctr.sv
// Module: i2s_tx_slotctr
// Counts bit slots in a stereo frame, moving on at each bit-clock falling
// edge, and drives the word-select clock so it changes only on those edges.
// Assumes: fall_i is the strobe from i2s_tx_clkgen; slot 0 follows reset.
module i2s_tx_slotctr
    import i2s_tx_pkg::*;
#(
    parameter int unsigned WORD_W = WORD_W_DEF
) (
    input  logic                                       clk,
    input  logic                                       rst_n,
    input  logic                                       fall_i,
    output logic [$clog2(frame_bits(WORD_W))-1:0]      slot_o,
    output logic                                       lrck_o
);
    localparam int unsigned FRAME_W = frame_bits(WORD_W);
    localparam int unsigned SLOT_W  = $clog2(FRAME_W);

    logic [SLOT_W-1:0] slot_q;
    logic [SLOT_W-1:0] slot_nxt;
    chan_e             lr_q;

    // Next slot number, wrapping at the end of the frame.
    always_comb begin
        if (slot_q == SLOT_W'(FRAME_W - 1)) begin
            slot_nxt = '0;
        end else begin
            slot_nxt = slot_q + 1'b1;
        end
    end

    // Slot counter and word select, both updated on bit-clock falling edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q <= '0;
            lr_q   <= CH_LEFT;
        end else if (fall_i) begin
            slot_q <= slot_nxt;
            lr_q   <= slot_chan(int'(slot_nxt), WORD_W);
        end
    end

    assign slot_o = slot_q;
    assign lrck_o = lr_q;

endmodule

// File: rtl/i2s_tx_shifter.sv
// Module: i2s_tx_shifter
// Holds the frame shift register and the last accepted stereo pair. On a
// load it takes the offered pair, or the held pair if none is offered, and
// drives its MSB. On each shift it drives the next bit. The bit that leaves
// first in the following frame is the LSB of this frame's right word.
// Assumes: load_i and shift_i are never high together.
module i2s_tx_shifter #(
    parameter int unsigned FRAME_W = 48
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_i,
    input  logic               shift_i,
    input  logic               valid_i,
    input  logic [FRAME_W-1:0] pair_i,
    output logic               sdata_o,
    output logic               underrun_o
);
    logic [FRAME_W-1:0] sr_q;
    logic [FRAME_W-1:0] held_q;
    logic [FRAME_W-1:0] word_sel;
    logic               sd_q;
    logic               urun_q;

    // Choose between the new pair and the repeated one.
    assign word_sel = valid_i ? pair_i : held_q;

    // Last accepted pair, kept for repetition after a missed slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_q <= '0;
        end else if (load_i) begin
            held_q <= word_sel;
        end
    end

    // Shift register and serial output bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q <= '0;
            sd_q <= 1'b0;
        end else if (load_i) begin
            sr_q <= {word_sel[FRAME_W-2:0], 1'b0};
            sd_q <= word_sel[FRAME_W-1];
        end else if (shift_i) begin
            sr_q <= {sr_q[FRAME_W-2:0], 1'b0};
            sd_q <= sr_q[FRAME_W-1];
        end
    end

    // Underrun flag, set again at every load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            urun_q <= 1'b0;
        end else if (load_i) begin
            urun_q <= !valid_i;
        end
    end

    assign sdata_o    = sd_q;
    assign underrun_o = urun_q;

endmodule

// File: rtl/i2s_dac_tx.sv
// Module: i2s_dac_tx
// Clock-master I2S transmitter for a stereo DAC. It forwards the master
// clock, makes the bit clock and the word-select clock, and takes one
// stereo pair per frame. The pair is accepted on the falling bit-clock edge
// that starts slot 1, so the MSB follows the word-select edge by one slot.
// Assumes: clk is the master audio clock; synchronous active-low reset.
module i2s_dac_tx
    import i2s_tx_pkg::*;
#(
    parameter int unsigned WORD_W   = WORD_W_DEF,
    parameter int unsigned MCLK_DIV = MCLK_DIV_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] pair_left_i,
    input  logic [WORD_W-1:0] pair_right_i,
    input  logic              pair_valid_i,
    output logic              pair_ready_o,
    output logic              frame_req_o,
    output logic              underrun_o,
    output logic              mclk_o,
    output logic              sck_o,
    output logic              lrck_o,
    output logic              sdata_o
);
    localparam int unsigned FRAME_W = frame_bits(WORD_W);
    localparam int unsigned SLOT_W  = $clog2(FRAME_W);

    logic              fall;
    logic              prefall;
    logic [SLOT_W-1:0] slot;
    logic              at_slot0;
    logic              load;
    logic              shift;

    // Master clock goes to the DAC unchanged.
    assign mclk_o = clk;

    i2s_tx_clkgen #(
        .DIV       (MCLK_DIV)
    ) u_clkgen (
        .clk       (clk),
        .rst_n     (rst_n),
        .sck_o     (sck_o),
        .fall_o    (fall),
        .prefall_o (prefall)
    );

    i2s_tx_slotctr #(
        .WORD_W (WORD_W)
    ) u_slotctr (
        .clk    (clk),
        .rst_n  (rst_n),
        .fall_i (fall),
        .slot_o (slot),
        .lrck_o (lrck_o)
    );

    // The load happens on the fall that leaves slot 0; every other fall shifts.
    assign at_slot0     = (slot == '0);
    assign load         = fall && at_slot0;
    assign shift        = fall && !at_slot0;
    assign pair_ready_o = load;
    assign frame_req_o  = prefall && at_slot0;

    i2s_tx_shifter #(
        .FRAME_W    (FRAME_W)
    ) u_shifter (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (load),
        .shift_i    (shift),
        .valid_i    (pair_valid_i),
        .pair_i     ({pair_left_i, pair_right_i}),
        .sdata_o    (sdata_o),
        .underrun_o (underrun_o)
    );

endmodule

// File: rtl/i2s_dac_tx_chk.sv
// Module: i2s_dac_tx_chk
// Assertion checker for i2s_dac_tx, attached with bind below. It checks the
// clock shape, edge alignment, frame pacing, handshake and reset at the ports.
// Assumes: the same parameters as the instance it is bound to.
module i2s_dac_tx_chk #(
    parameter int unsigned WORD_W   = 24,
    parameter int unsigned MCLK_DIV = 4
) (
    input logic clk,
    input logic rst_n,
    input logic pair_valid_i,
    input logic pair_ready_o,
    input logic frame_req_o,
    input logic underrun_o,
    input logic sck_o,
    input logic lrck_o,
    input logic sdata_o
);
    localparam int unsigned FRAME_CYC = 2 * WORD_W * MCLK_DIV;
    localparam int unsigned GAP_W     = $clog2(FRAME_CYC + 1);
    localparam int unsigned FALL_W    = $clog2(WORD_W + 1);

    logic [GAP_W-1:0]  gap_q;
    logic              seen_q;
    logic              sck_d;
    logic              lr_d;
    logic [FALL_W-1:0] falls_q;
    logic              lr_chg;
    logic              sck_fell;

    assign lr_chg   = (lr_d != lrck_o);
    assign sck_fell = sck_d && !sck_o;

    // Cycles since the last acceptance slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q  <= '0;
            seen_q <= 1'b0;
        end else if (pair_ready_o) begin
            gap_q  <= '0;
            seen_q <= 1'b1;
        end else begin
            gap_q  <= gap_q + 1'b1;
        end
    end

    // Bit-clock falls counted between word-select changes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_d   <= 1'b0;
            lr_d    <= 1'b0;
            falls_q <= '0;
        end else begin
            sck_d <= sck_o;
            lr_d  <= lrck_o;
            if (lr_chg) begin
                falls_q <= '0;
            end else if (sck_fell) begin
                falls_q <= falls_q + 1'b1;
            end
        end
    end

    // R1: the bit clock stays high two cycles, then low two cycles.
    a_r1_sck_high: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sck_o) |=> sck_o ##1 !sck_o);
    a_r1_sck_low: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sck_o) |=> !sck_o ##1 sck_o);

    // R2: word select changes only together with a bit-clock fall.
    a_r2_lrck_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (lrck_o != $past(lrck_o)) |-> $fell(sck_o));

    // R2: each half-frame spans the word width in bit-clock periods.
    a_r2_half_len: assert property (@(posedge clk) disable iff (!rst_n)
        lr_chg |-> (falls_q == FALL_W'(WORD_W - 1)));

    // R3: serial data changes only together with a bit-clock fall.
    a_r3_sdata_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (sdata_o != $past(sdata_o)) |-> $fell(sck_o));

    // R5: the request strobe comes one cycle before the acceptance slot.
    a_r5_req_then_ready: assert property (@(posedge clk) disable iff (!rst_n)
        frame_req_o |=> pair_ready_o);

    // R6: the acceptance slot lasts one cycle.
    a_r6_ready_single: assert property (@(posedge clk) disable iff (!rst_n)
        pair_ready_o |=> !pair_ready_o);

    // R6: acceptance slots are exactly one frame apart.
    a_r6_ready_period: assert property (@(posedge clk) disable iff (!rst_n)
        (pair_ready_o && seen_q) |-> (gap_q == GAP_W'(FRAME_CYC - 1)));

    // R7: a missed slot raises the flag and an accepted pair clears it.
    a_r7_underrun_set: assert property (@(posedge clk) disable iff (!rst_n)
        (pair_ready_o && !pair_valid_i) |=> underrun_o);
    a_r7_underrun_clr: assert property (@(posedge clk) disable iff (!rst_n)
        (pair_ready_o && pair_valid_i) |=> !underrun_o);
    a_r7_underrun_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !pair_ready_o |=> $stable(underrun_o));

    // R8: reset drives the serial outputs and the flag low.
    a_r8_reset_low: assert property (@(posedge clk)
        !rst_n |=> (!sck_o && !lrck_o && !sdata_o && !underrun_o));

endmodule

bind i2s_dac_tx i2s_dac_tx_chk #(
    .WORD_W       (WORD_W),
    .MCLK_DIV     (MCLK_DIV)
) u_i2s_dac_tx_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .pair_valid_i (pair_valid_i),
    .pair_ready_o (pair_ready_o),
    .frame_req_o  (frame_req_o),
    .underrun_o   (underrun_o),
    .sck_o        (sck_o),
    .lrck_o       (lrck_o),
    .sdata_o      (sdata_o)
);

// File: tb/test_i2s_dac_tx.sv
`timescale 1ns/1ps
// Bench: test_i2s_dac_tx
// Directed scenarios drive the transmitter. A monitor decodes the serial
// stream like a DAC, sampling at rising bit-clock edges, and counts
// clock-shape and edge-alignment violations.
module test_i2s_dac_tx;
    localparam int W   = 24;
    localparam int FRM = 192;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] left = '0;
    logic [W-1:0] right = '0;
    logic         valid = 1'b0;
    logic         ready, req, urun, mclk, sck, lrck, sdata;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    i2s_dac_tx i_i2s_dac_tx (
        .clk          (clk),
        .rst_n        (rst_n),
        .pair_left_i  (left),
        .pair_right_i (right),
        .pair_valid_i (valid),
        .pair_ready_o (ready),
        .frame_req_o  (req),
        .underrun_o   (urun),
        .mclk_o       (mclk),
        .sck_o        (sck),
        .lrck_o       (lrck),
        .sdata_o      (sdata)
    );

    // 50 MHz clock.
    always #10 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // Monitor state.
    logic         m_sck, m_lr, m_sd, d_lr;
    logic [W-1:0] acc;
    int since_rise, high_cnt, half_cnt, rise_seen;
    int lr_bad = 0, sd_bad = 0, per_bad = 0, high_bad = 0, half_bad = 0;
    int dec_n;
    logic [W-1:0] dec_l [0:63];
    logic [W-1:0] dec_r [0:63];

    // Expected stream.
    int exp_n;
    logic [W-1:0] exp_l [0:63];
    logic [W-1:0] exp_r [0:63];
    logic [W-1:0] last_l, last_r;
    int prev_req;
    int req_bad = 0;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Decoder and edge monitor, sampled mid-cycle.
    always @(negedge clk) begin
        if (!rst_n) begin
            m_sck = 0; m_lr = 0; m_sd = 0; d_lr = 0; acc = '0;
            since_rise = 0; high_cnt = 0; half_cnt = 0; rise_seen = 0; dec_n = 0;
        end else begin
            if (lrck != m_lr && !(m_sck && !sck)) lr_bad++;
            if (sdata != m_sd && !(m_sck && !sck)) sd_bad++;
            since_rise++;
            if (sck) high_cnt++;
            if (m_sck && !sck) begin
                if (high_cnt != 2) high_bad++;
                high_cnt = 0;
            end
            if (!m_sck && sck) begin
                if (rise_seen != 0 && since_rise != 4) per_bad++;
                rise_seen = 1;
                since_rise = 0;
                if (lrck != d_lr) begin
                    if (half_cnt != W) half_bad++;
                    half_cnt = 1;
                    if (d_lr == 1'b0) begin
                        dec_l[dec_n] = {acc[W-2:0], sdata};
                    end else begin
                        dec_r[dec_n] = {acc[W-2:0], sdata};
                        if (dec_n < 63) dec_n++;
                    end
                    acc = '0;
                    d_lr = lrck;
                end else begin
                    half_cnt++;
                    acc = {acc[W-2:0], sdata};
                end
            end
            m_sck = sck; m_lr = lrck; m_sd = sdata;
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        valid = 1'b0;
        repeat (3) @(negedge clk);
        exp_n = 0; last_l = '0; last_r = '0; prev_req = -1;
    endtask

    task automatic release_reset();
        rst_n = 1'b1;
    endtask

    // Offer one pair at the next acceptance slot (or skip it).
    task automatic feed(input logic [W-1:0] l, input logic [W-1:0] r, input bit skip);
        do @(negedge clk); while (!req);
        chk("R5 ready low with request", ready, 0);
        if (prev_req >= 0 && ((cyc - prev_req) % FRM) != 0) req_bad++;
        prev_req = cyc;
        @(negedge clk);
        chk("R5 ready after request", ready, 1);
        chk("R5 request one cycle", req, 0);
        left = l; right = r; valid = !skip;
        if (!skip) begin last_l = l; last_r = r; end
        exp_l[exp_n] = last_l; exp_r[exp_n] = last_r; exp_n++;
        @(negedge clk);
        valid = 1'b0;
        chk("R6 ready single cycle", ready, 0);
        chk("R7 underrun flag", urun, {63'b0, skip});
    endtask

    // Wait for the decoder, then compare the whole expected stream.
    task automatic compare_stream(input string tag);
        for (int i = 0; i < 800 && dec_n < exp_n; i++) @(negedge clk);
        for (int k = 0; k < exp_n; k++) begin
            chk({tag, " left"}, dec_l[k], exp_l[k]);
            chk({tag, " right"}, dec_r[k], exp_r[k]);
        end
    endtask

    task automatic t_reset();
        do_reset();
        chk("R8 sck in reset", sck, 0);
        chk("R8 lrck in reset", lrck, 0);
        chk("R8 sdata in reset", sdata, 0);
        chk("R8 req in reset", req, 0);
        chk("R8 ready in reset", ready, 0);
        chk("R8 underrun in reset", urun, 0);
        release_reset();
    endtask

    task automatic t_clocks();
        @(posedge clk); #2;
        chk("R1 mclk high", mclk, 1);
        @(negedge clk); #2;
        chk("R1 mclk low", mclk, 0);
    endtask

    task automatic t_full_scale();
        feed(24'h800000, 24'h7FFFFF, 0);
        feed(24'h7FFFFF, 24'h800000, 0);
        feed(24'h000000, 24'h000000, 0);
        feed(24'hFFFFFF, 24'h000001, 0);
        compare_stream("R6 full scale");
    endtask

    task automatic t_patterns();
        t_reset();
        feed(24'hA5A5A5, 24'h5A5A5A, 0);
        feed(24'h000001, 24'h800000, 0);
        feed(24'h800001, 24'h400002, 0);
        compare_stream("R4 bit order");
    endtask

    task automatic t_underrun();
        t_reset();
        feed(24'h123456, 24'hFEDCBA, 0);
        feed(24'h111111, 24'h222222, 1);
        feed(24'h0F0F0F, 24'hF0F0F0, 0);
        feed(24'h333333, 24'h444444, 1);
        feed(24'h555555, 24'h666666, 1);
        compare_stream("R7 repeat");
    endtask

    task automatic t_first_underrun();
        t_reset();
        feed(24'hABCDEF, 24'h654321, 1);
        compare_stream("R8 zeros after reset");
    endtask

    task automatic t_mid_reset();
        t_reset();
        feed(24'hFFFFFF, 24'hFFFFFF, 0);
        do @(negedge clk); while (!(lrck && sck && sdata));
        rst_n = 1'b0;
        @(negedge clk);
        chk("R8 mid reset sck", sck, 0);
        chk("R8 mid reset lrck", lrck, 0);
        chk("R8 mid reset sdata", sdata, 0);
        rst_n = 1'b1;
    endtask

    initial begin
        t_reset();
        t_clocks();
        t_full_scale();
        t_patterns();
        t_underrun();
        t_first_underrun();
        t_mid_reset();
        chk("R1 sck period", per_bad, 0);
        chk("R1 sck high time", high_bad, 0);
        chk("R2 lrck edge alignment", lr_bad, 0);
        chk("R2 half-frame length", half_bad, 0);
        chk("R3 sdata edge alignment", sd_bad, 0);
        chk("R5 request spacing", req_bad, 0);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule